// File: doc/BRIEF.md
# Change-Triggered Five-Channel Capture Engine

This block records five digital input channels into an on-chip sample buffer and returns the recorded trace to a host over a byte stream. The channels first pass through a two-flop synchronizer. A clock divider then produces a fixed sample strobe, 10 kHz with the default parameters. When the host arms the engine, it waits for any channel to change. The first change starts the capture. The engine then fills the whole buffer, one sample per strobe, and only after that does it send the samples back, starting with the newest.

The host side is a pair of 8-bit valid/ready byte streams, and a serial link can sit in front of them. A small command decoder reads incoming bytes. It acts on three opcodes: clear, arm and identify. It accepts every other byte and discards it, including five-byte long commands that would otherwise request rates or trigger settings. An armed flag output shows that the engine is waiting for a trigger or is recording.

Top module: `lcap_capture_engine`

## Requirements
- R1: Each capture stores exactly DEPTH samples (default 4096), and DEPTH bytes are then sent, no more and no fewer.
- R2: Samples are spaced by a fixed CLK_HZ/SAMPLE_HZ clock cycles. No host byte changes that spacing, including a long command that carries rate arguments.
- R3: Input bit i is channel i: 0 chip select, 1 MISO, 2 clock, 3 MOSI, 4 auxiliary. Each sample goes out as one byte with the channels in bits 4:0 in that order and bits 7:5 zero.
- R4: While armed, the first change of the synchronized inputs triggers the capture. The synchronized value that shows the change is stored as sample 0. Without a change, no capture starts.
- R5: armed_o goes high the cycle after an arm command is accepted. It drops in the cycle after the last sample is written.
- R6: No sample byte is offered before the capture completes. Samples are sent from the newest (index DEPTH-1) to the oldest (index 0).
- R7: Byte 0x00 is the clear command, 0x01 is arm and 0x02 is identify. Identify is answered with exactly the four bytes 0x31, 0x41, 0x4C, 0x53 ("1ALS").
- R8: A byte with bit 7 set starts a long command. It and the next four bytes are consumed without any effect, even when those bytes hold opcode values.
- R9: Any other short byte (bit 7 clear, value above 0x02) is consumed without effect.
- R10: An arm command is honoured only when the engine is idle. Arm bytes that arrive during a capture do not restart or extend it.
- R11: A clear command aborts an armed wait, a capture or a transfer in progress. armed_o and tx_valid_o are low in the following cycle.
- R12: While tx_valid_o is high and tx_ready_i is low, tx_data_o holds its value and tx_valid_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_i | input | 5 | Asynchronous channel inputs, bit i = channel i |
| rx_valid_i | input | 1 | Host byte present |
| rx_data_i | input | 8 | Host command byte |
| rx_ready_o | output | 1 | Engine accepts a host byte (always high) |
| tx_valid_o | output | 1 | Reply or sample byte present |
| tx_data_o | output | 8 | Reply or sample byte |
| tx_ready_i | input | 1 | Host takes the offered byte |
| armed_o | output | 1 | Engine waiting for a trigger or recording |

## Verification
The capture path is driven with a table of channel patterns, one value per sample slot. The table uses each channel alone, all channels together and mixed codes. This separates a swapped bit order, an off-by-one in sample spacing and a reversed transfer order. The same table is replayed inverted and masked, and the engine is re-armed between captures, so stale buffer contents or a stuck trigger would show up. The command path is tried with long commands whose argument bytes hold real opcodes, with unknown short bytes, with arm bytes during a capture, and with clear bytes while armed and during a transfer. Each of these shows whether the decoder stays aligned to command boundaries.

// File: rtl/lcap_pkg.sv
package lcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DUMP    = 2'd3
    } cap_state_e;

    localparam logic [7:0] OP_CLEAR = 8'h00;
    localparam logic [7:0] OP_ARM   = 8'h01;
    localparam logic [7:0] OP_IDENT = 8'h02;
    localparam int unsigned LONG_ARGS = 4;

endpackage

// File: rtl/lcap_sync.sv
module lcap_sync #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/lcap_tick.sv
module lcap_tick #(
    parameter int unsigned DIV = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_comb begin
        if (clear_i || tick_o) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // strobes are never back to back: spacing is the fixed divider
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/lcap_cmd_decode.sv
module lcap_cmd_decode
    import lcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_data_i,
    output logic       rx_ready_o,
    output logic       op_clear_o,
    output logic       op_arm_o,
    output logic       op_ident_o
);
    typedef struct packed {
        logic [2:0] skip;
    } dec_t;

    dec_t st_d, st_q;
    logic take, at_cmd;

    assign rx_ready_o = 1'b1;
    assign take       = rx_valid_i && rx_ready_o;
    assign at_cmd     = (st_q.skip == '0);

    always_comb begin
        st_d = st_q;
        if (take) begin
            if (!at_cmd)          st_d.skip = st_q.skip - 1'b1;
            else if (rx_data_i[7]) st_d.skip = 3'(LONG_ARGS);
        end
    end

    assign op_clear_o = take && at_cmd && (rx_data_i == OP_CLEAR);
    assign op_arm_o   = take && at_cmd && (rx_data_i == OP_ARM);
    assign op_ident_o = take && at_cmd && (rx_data_i == OP_IDENT);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // each argument byte of a long command counts the skip down by one
    assert_arg_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.skip != '0 && rx_valid_i) |=> (st_q.skip == $past(st_q.skip) - 3'd1));
endmodule

// File: rtl/lcap_capture_engine.sv
module lcap_capture_engine
    import lcap_pkg::*;
#(
    parameter int unsigned CH        = 5,
    parameter int unsigned DEPTH     = 4096,
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned SAMPLE_HZ = 10_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] ch_i,
    input  logic          rx_valid_i,
    input  logic [7:0]    rx_data_i,
    output logic          rx_ready_o,
    output logic          tx_valid_o,
    output logic [7:0]    tx_data_o,
    input  logic          tx_ready_i,
    output logic          armed_o
);
    localparam int unsigned AW  = $clog2(DEPTH);
    localparam int unsigned DIV = CLK_HZ / SAMPLE_HZ;
    localparam int unsigned PAD = 8 - CH;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        cap_state_e    state;
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic          id_busy;
        logic [1:0]    id_idx;
        logic [CH-1:0] prev;
    } eng_t;

    eng_t st_d, st_q;

    logic [CH-1:0] sync_ch;
    logic          tick, tick_clr;
    logic          op_clear, op_arm, op_ident;
    logic          we;
    logic [AW-1:0] waddr;
    logic          dump_fire;
    logic [7:0]    id_byte;
    logic [CH-1:0] buf_mem [DEPTH];

    lcap_sync #(.W(CH)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ch_i), .sync_o(sync_ch)
    );

    lcap_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clear_i(tick_clr), .tick_o(tick)
    );

    lcap_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n),
        .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o),
        .op_clear_o(op_clear), .op_arm_o(op_arm), .op_ident_o(op_ident)
    );

    always_comb begin
        unique case (st_q.id_idx)
            2'd0:    id_byte = 8'h31;
            2'd1:    id_byte = 8'h41;
            2'd2:    id_byte = 8'h4C;
            default: id_byte = 8'h53;
        endcase
    end

    assign tx_valid_o = st_q.id_busy || (st_q.state == ST_DUMP);
    assign tx_data_o  = st_q.id_busy ? id_byte : {{PAD{1'b0}}, buf_mem[st_q.rd_ptr]};
    assign dump_fire  = (st_q.state == ST_DUMP) && !st_q.id_busy && tx_ready_i;
    assign armed_o    = (st_q.state == ST_ARMED) || (st_q.state == ST_CAPTURE);

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_ch;
        we        = 1'b0;
        waddr     = st_q.wr_ptr;
        tick_clr  = 1'b0;

        unique case (st_q.state)
            ST_IDLE: if (op_arm) st_d.state = ST_ARMED;
            ST_ARMED: begin
                if (sync_ch != st_q.prev) begin
                    we          = 1'b1;
                    waddr       = '0;
                    tick_clr    = 1'b1;
                    st_d.wr_ptr = AW'(1);
                    st_d.state  = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                if (tick) begin
                    we = 1'b1;
                    if (st_q.wr_ptr == LAST_IDX) begin
                        st_d.state  = ST_DUMP;
                        st_d.rd_ptr = LAST_IDX;
                    end else begin
                        st_d.wr_ptr = st_q.wr_ptr + 1'b1;
                    end
                end
            end
            default: begin
                if (dump_fire) begin
                    if (st_q.rd_ptr == '0) st_d.state  = ST_IDLE;
                    else                   st_d.rd_ptr = st_q.rd_ptr - 1'b1;
                end
            end
        endcase

        if (st_q.id_busy) begin
            if (tx_ready_i) begin
                if (st_q.id_idx == 2'd3) st_d.id_busy = 1'b0;
                st_d.id_idx = st_q.id_idx + 1'b1;
            end
        end else if (op_ident && st_q.state != ST_DUMP) begin
            st_d.id_busy = 1'b1;
            st_d.id_idx  = 2'd0;
        end

        if (op_clear) begin
            st_d.state   = ST_IDLE;
            st_d.id_busy = 1'b0;
            st_d.id_idx  = 2'd0;
            we           = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (we) buf_mem[waddr] <= sync_ch;
    end

    // a change seen while armed starts recording
    assert_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_ARMED && sync_ch != st_q.prev && !op_clear)
        |=> (st_q.state == ST_CAPTURE));

    // the flag only drops on its own once the last slot was filled
    assert_full_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(armed_o) && !$past(op_clear)) |-> ($past(st_q.wr_ptr) == LAST_IDX));

    // arm bytes during a capture do not send the engine back to waiting
    assert_arm_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_CAPTURE && op_arm && !op_clear) |=> (st_q.state != ST_ARMED));

    // offered byte is held under backpressure
    assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i && !op_clear) |=> (tx_valid_o && $stable(tx_data_o)));

    // clear leaves nothing armed and nothing offered
    assert_clear_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_clear |=> (!armed_o && !tx_valid_o));
endmodule

// File: tb/tb_lcap_capture_engine.sv
`timescale 1ns/1ps
module tb_lcap_capture_engine;
    localparam int DEPTH = 16;
    localparam int DIV   = 4;
    localparam logic [4:0] VEC [16] = '{
        5'h01, 5'h02, 5'h04, 5'h08, 5'h10, 5'h1F, 5'h00, 5'h15,
        5'h0A, 5'h13, 5'h1C, 5'h07, 5'h18, 5'h03, 5'h0C, 5'h11
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] ch;
    logic       rx_valid, rx_ready, tx_valid, tx_ready, armed;
    logic [7:0] rx_data, tx_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lcap_capture_engine #(.CH(5), .DEPTH(DEPTH), .CLK_HZ(DIV * 10000), .SAMPLE_HZ(10000)) dut (
        .clk(clk), .rst_n(rst_n), .ch_i(ch),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
        .armed_o(armed)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_valid();
        for (int n = 0; n < 50 && !tx_valid; n++) @(negedge clk);
    endtask

    task automatic collect_id();
        logic [7:0] exp [4] = '{8'h31, 8'h41, 8'h4C, 8'h53};
        tx_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wait_valid();
            check(tx_valid && tx_data == exp[i], "R7 ident byte", tx_data, exp[i]);
            @(negedge clk);
        end
        tx_ready = 1'b0;
        check(!tx_valid, "R7 ident length", tx_valid, 0);
    endtask

    // drive pattern k one slot before sample k is taken
    task automatic capture(input logic [4:0] m, input bit arm_mid);
        @(negedge clk);
        ch = VEC[0] ^ m;
        check(armed && !tx_valid, "R5 armed before trigger", armed, 1);
        for (int k = 1; k < DEPTH; k++) begin
            repeat (DIV) @(posedge clk);
            @(negedge clk);
            ch = VEC[k] ^ m;
            if (arm_mid && k == 2) begin rx_valid = 1'b1; rx_data = 8'h01; end
            if (arm_mid && k == 3) rx_valid = 1'b0;
            check(armed && !tx_valid, "R6 no output while recording", {armed, tx_valid}, 2);
        end
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(armed, "R5 armed until last sample", armed, 1);
        @(negedge clk);
        check(!armed, "R5 armed drops after last sample", armed, 0);
        check(tx_valid, "R6 transfer starts after completion", tx_valid, 1);
    endtask

    task automatic collect_dump(input logic [4:0] m, input bit bp);
        logic [7:0] hold;
        if (bp) begin
            tx_ready = 1'b0;
            hold = tx_data;
            repeat (3) @(negedge clk);
            check(tx_valid && tx_data == hold, "R12 byte held under backpressure", tx_data, hold);
        end
        tx_ready = 1'b1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            wait_valid();
            check(tx_valid && tx_data == {3'b000, VEC[i] ^ m}, "R3 R6 sample byte newest first",
                  tx_data, {3'b000, VEC[i] ^ m});
            @(negedge clk);
        end
        tx_ready = 1'b0;
        check(!tx_valid && !armed, "R1 exactly DEPTH bytes", tx_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ch = '0; rx_valid = 1'b0; rx_data = '0; tx_ready = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(!armed && !tx_valid && rx_ready, "reset state", {armed, tx_valid, rx_ready}, 1);

        send(8'h02);
        collect_id();

        // R8: long command whose arguments look like opcodes
        send(8'h80); send(8'h02); send(8'h01); send(8'h00); send(8'h55);
        repeat (3) @(negedge clk);
        check(!tx_valid && !armed, "R8 long command args ignored", {armed, tx_valid}, 0);
        send(8'h02);
        collect_id();

        // R9: unknown short bytes
        send(8'h11); send(8'h7F);
        repeat (3) @(negedge clk);
        check(!tx_valid && !armed, "R9 unknown command ignored", {armed, tx_valid}, 0);

        // R4 R5: arm, no trigger without change
        send(8'h01);
        check(armed, "R5 armed after run", armed, 1);
        repeat (20) @(negedge clk);
        check(armed && !tx_valid, "R4 no trigger without change", {armed, tx_valid}, 2);
        capture(5'h00, 1'b0);
        collect_dump(5'h00, 1'b1);

        // R2 R10: rate request ignored, arm during capture ignored
        send(8'h80); send(8'h00); send(8'h00); send(8'h00); send(8'h07);
        send(8'h01);
        capture(5'h1F, 1'b1);
        collect_dump(5'h1F, 1'b0);
        repeat (5) @(negedge clk);
        check(!armed && !tx_valid, "R10 arm during capture ignored", {armed, tx_valid}, 0);

        // R11: clear while armed
        send(8'h01);
        check(armed, "R5 armed again", armed, 1);
        send(8'h00);
        check(!armed, "R11 clear aborts armed wait", armed, 0);
        @(negedge clk) ch = ch ^ 5'h01;
        repeat (10) @(negedge clk);
        check(!armed && !tx_valid, "R11 no capture after clear", {armed, tx_valid}, 0);

        // R11: clear during transfer
        send(8'h01);
        capture(5'h05, 1'b0);
        tx_ready = 1'b1;
        for (int i = DEPTH - 1; i > DEPTH - 3; i--) begin
            wait_valid();
            check(tx_data == {3'b000, VEC[i] ^ 5'h05}, "R6 partial transfer", tx_data, {3'b000, VEC[i] ^ 5'h05});
            @(negedge clk);
        end
        tx_ready = 1'b0;
        send(8'h00);
        check(!tx_valid && !armed, "R11 clear aborts transfer", {armed, tx_valid}, 0);
        send(8'h02);
        collect_id();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule